// File: doc/BRIEF.md
# Automatic I2C Master Sequencer

This block runs a whole addressed I2C transfer on its own after a single launch command. The command gives a byte count, a read/write flag, a flag that asks for a stop at the end, and a run bit; the 7-bit target address comes in on its own port. The sequencer issues a start, or a repeated start if it still holds the bus, then sends the address byte. It moves the requested number of bytes through a byte-wide transmit and receive stream, checks or gives every acknowledge, and then releases the bus with a stop or keeps it with SCL parked low.

Bit timing is not generated here. Every `bit_tick` strobe moves the current bit cell on by one quarter period, so four strobes make one SCL period. A state code shows the sequencer's position on the bus. Status flags report success, lost arbitration, a device that refused a data byte and an address that nobody acknowledged. If a slave holds SDA low, two manual commands let software clear the bus: one clocks nine pulses with SDA released, and the other sends a stop.

Top module: `i2cseq_master`

## Requirements
- R1: After reset, SCL and SDA are released (1), `busy` is 0, `state_code` is 0 and `status` is 0.
- R2: A launch is accepted only when `launch` is high, `launch_word[31]` (run) is 1 and the sequencer is idle or holding the bus. Bit 16 selects read (1) or write (0), bit 17 requests a final stop, and bits [CNT_W-1:0] hold the byte count. A launch with bit 31 clear is ignored.
- R3: A write sends a start and the address byte {addr[6:0], 0}, MSB first. It then sends each byte taken from `tx_data`, with exactly one `tx_take` pulse per byte, ends with a stop and sets `status[0]` (done).
- R4: A read sends address byte {addr[6:0], 1} and delivers each received byte MSB first on `rx_data` with a one-cycle `rx_valid`. The master acknowledges (SDA 0) every byte except the last, which it answers with SDA 1.
- R5: `busy` rises in the cycle after an accepted launch, with `state_code` 1 (start). It stays high until the stop completes, or until the parked wait state is reached. State codes: idle 0, start 1, restart 2, stop 3, address 5, read 9, write 10, no-ack 11, lost 12, wait 13.
- R6: `status` bits: 0 done, 1 arbitration loss or stuck bus, 2 data byte not acknowledged, 3 address not acknowledged. A `status_rd` pulse clears them, and an accepted launch clears them. Done never coexists with an error bit.
- R7: An address that gets no acknowledge sets `status[3]`, takes no transmit byte and ends with a stop.
- R8: A write byte that gets no acknowledge sets `status[2]`, takes no further byte and ends with a stop.
- R9: With the stop flag clear, the transfer ends with SCL held low, `state_code` 13, `busy` 0 and done set, and no stop on the bus. The next launch produces a repeated start without an intervening stop.
- R10: A byte count of zero sends only the address and then finishes normally with done set.
- R11: If SDA is low when a launch arrives from idle, the sequencer enters state 12, sets `status[1]`, leaves both lines released and ignores further launches until a manual command.
- R12: `man_clk9` produces exactly nine SCL pulses with SDA released while `state_code` shows 9, then returns to idle. `man_stop` produces a stop condition and returns to idle without setting done.
- R13: If the master releases SDA for an address or write data bit but samples it low, it sets `status[1]`, releases both lines and returns to idle.
- R14: While SCL stays high within an address or data bit, the master does not change SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Quarter-bit strobe from the timing generator |
| launch | input | 1 | Launch strobe, qualified by the run bit |
| launch_word | input | 32 | Count, direction, stop flag and run bit |
| launch_addr | input | 7 | Target address |
| man_clk9 | input | 1 | Manual nine-pulse clock-out command |
| man_stop | input | 1 | Manual stop command |
| status_rd | input | 1 | Clears the status flags |
| tx_data | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Pulse: `tx_data` consumed |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` is new |
| sda_i | input | 1 | Sensed SDA level of the wired bus |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive, 0 pulls low, 1 releases |
| busy | output | 1 | Master busy |
| state_code | output | 4 | Current sequencer state code |
| status | output | 4 | Done and error flags |

## Verification
The bound checker holds on every cycle a set of local invariants. An idle master with both lines released, a parked wait with SCL low, a lost state that never touches the bus, done and error flags that never coexist, byte strobes that occur only in their own phases, and SDA held steady during every high SCL phase of a bit. Whole-transfer behaviour can only be shown by the bench's scenarios against its behavioural slave. That covers the address and data bytes on the wire, the acknowledge pattern of a read, the error paths, the repeated start after a parked transfer, and the nine-pulse recovery of a stuck SDA.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_START   = 4'd1,
      ST_RESTART = 4'd2,
      ST_STOP    = 4'd3,
      ST_ADDR    = 4'd5,
      ST_READ    = 4'd9,
      ST_WRITE   = 4'd10,
      ST_NOACK   = 4'd11,
      ST_LOST    = 4'd12,
      ST_WAIT    = 4'd13
   } seq_state_e;

   typedef enum logic [2:0] {
      CELL_START,
      CELL_RESTART,
      CELL_STOP,
      CELL_BIT,
      CELL_PARK
   } cell_kind_e;

   localparam int W_RW   = 16;
   localparam int W_STOP = 17;
   localparam int W_RUN  = 31;

   localparam int S_DONE  = 0;
   localparam int S_ABORT = 1;
   localparam int S_DNACK = 2;
   localparam int S_NODEV = 3;

endpackage

// File: rtl/i2cseq_bitcell.sv
module i2cseq_bitcell
   import i2cseq_pkg::*;
#(
   parameter int SAMPLE_Q = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  cell_kind_e kind,
   input  logic       val,
   input  logic       release_bus,
   input  logic       sda_s,
   output logic       scl_o,
   output logic       sda_o,
   output logic       done,
   output logic       smp
);

   localparam logic [1:0] LAST_Q = 2'd3;
   localparam logic [1:0] SMP_Q  = 2'(SAMPLE_Q);

   if (SAMPLE_Q < 2 || SAMPLE_Q > 3) begin : g_bad_sample
      $error("SAMPLE_Q must be 2 or 3");
   end

   logic       active;
   logic [1:0] q;

   // line levels {scl, sda} for quarter qq of a cell
   function automatic logic [1:0] levels(cell_kind_e k, logic [1:0] qq,
                                         logic v, logic prev);
      logic [1:0] r;
      case (k)
         CELL_START:   r = {1'b1, ~qq[1]};
         CELL_RESTART: r = {qq[1], (qq == 2'd0) ? prev : (qq != 2'd3)};
         CELL_STOP:    r = {qq[1], (qq == 2'd0) ? prev : (qq == 2'd3)};
         CELL_PARK:    r = {1'b0, (qq == 2'd0) ? prev : 1'b1};
         default:      r = {qq[1], (qq == 2'd0) ? prev : v};
      endcase
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         q      <= 2'd0;
         scl_o  <= 1'b1;
         sda_o  <= 1'b1;
         done   <= 1'b0;
         smp    <= 1'b1;
      end else begin
         done <= 1'b0;
         if (release_bus) begin
            active <= 1'b0;
            scl_o  <= 1'b1;
            sda_o  <= 1'b1;
         end else if (go) begin
            active         <= 1'b1;
            q              <= 2'd0;
            {scl_o, sda_o} <= levels(kind, 2'd0, val, sda_o);
         end else if (active && tick) begin
            if (q == SMP_Q) smp <= sda_s;
            if (q == LAST_Q) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               q              <= q + 2'd1;
               {scl_o, sda_o} <= levels(kind, q + 2'd1, val, sda_o);
            end
         end
      end
   end

endmodule

// File: rtl/i2cseq_bytecnt.sv
module i2cseq_bytecnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last,
   output logic             empty
);

   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left <= '0;
      else if (load)             left <= load_val;
      else if (dec && left != 0) left <= left - 1'b1;
   end

   assign last  = (left == CNT_W'(1));
   assign empty = (left == '0);

endmodule

// File: rtl/i2cseq_master.sv
module i2cseq_master
   import i2cseq_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bit_tick,
   input  logic        launch,
   input  logic [31:0] launch_word,
   input  logic [6:0]  launch_addr,
   input  logic        man_clk9,
   input  logic        man_stop,
   input  logic        status_rd,
   input  logic [7:0]  tx_data,
   output logic        tx_take,
   output logic [7:0]  rx_data,
   output logic        rx_valid,
   input  logic        sda_i,
   output logic        scl_o,
   output logic        sda_o,
   output logic        busy,
   output logic [3:0]  state_code,
   output logic [3:0]  status
);

   localparam logic [3:0] ACK_SLOT = 4'd8;
   localparam logic [3:0] LSB_SLOT = 4'd7;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("CNT_W must be within 1..16");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be within 0..3");
   end

   // SDA input synchroniser, depth chosen by parameter
   logic sda_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_s = sda_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else begin
            chain[0] <= sda_i;
            for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
         end
      end
      assign sda_s = chain[SYNC_STAGES-1];
   end

   seq_state_e st;
   cell_kind_e kind_q;
   logic [3:0] bit_idx, status_q;
   logic [7:0] shreg, rx_q;
   logic       stop_q, man_q, park_q, err_q;
   logic       go_q, val_q, rel_q, take_q, rxv_q, cnt_load_q, cnt_dec_q;
   logic       cell_done, cell_smp, cnt_last, cnt_empty;
   logic       unused_word;

   assign unused_word = ^launch_word;

   i2cseq_bitcell #(.SAMPLE_Q(3)) u_cell (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .go(go_q), .kind(kind_q),
      .val(val_q), .release_bus(rel_q), .sda_s(sda_s), .scl_o(scl_o),
      .sda_o(sda_o), .done(cell_done), .smp(cell_smp)
   );

   i2cseq_bytecnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load_q),
      .load_val(launch_word[CNT_W-1:0]), .dec(cnt_dec_q),
      .last(cnt_last), .empty(cnt_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; kind_q <= CELL_BIT; bit_idx <= '0; status_q <= '0;
         shreg <= '0; rx_q <= '0; stop_q <= 1'b0; man_q <= 1'b0;
         park_q <= 1'b0; err_q <= 1'b0; go_q <= 1'b0; val_q <= 1'b1;
         rel_q <= 1'b0; take_q <= 1'b0; rxv_q <= 1'b0;
         cnt_load_q <= 1'b0; cnt_dec_q <= 1'b0;
      end else begin
         go_q <= 1'b0; rel_q <= 1'b0; take_q <= 1'b0; rxv_q <= 1'b0;
         cnt_load_q <= 1'b0; cnt_dec_q <= 1'b0;
         if (status_rd) status_q <= '0;
         case (st)
            ST_IDLE, ST_WAIT: begin
               if (st == ST_WAIT && park_q) begin
                  if (cell_done) begin
                     park_q           <= 1'b0;
                     status_q[S_DONE] <= 1'b1;
                  end
               end else if (launch && launch_word[W_RUN]) begin
                  status_q   <= '0;
                  err_q      <= 1'b0;
                  man_q      <= 1'b0;
                  stop_q     <= launch_word[W_STOP];
                  shreg      <= {launch_addr, launch_word[W_RW]};
                  cnt_load_q <= 1'b1;
                  if (st == ST_WAIT) begin
                     st <= ST_RESTART; go_q <= 1'b1; kind_q <= CELL_RESTART;
                  end else if (!sda_s) begin
                     st <= ST_LOST; err_q <= 1'b1; status_q[S_ABORT] <= 1'b1;
                  end else begin
                     st <= ST_START; go_q <= 1'b1; kind_q <= CELL_START;
                  end
               end else if (st == ST_IDLE && man_clk9) begin
                  st <= ST_READ; man_q <= 1'b1; bit_idx <= '0;
                  go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= 1'b1;
               end else if (st == ST_IDLE && man_stop) begin
                  st <= ST_STOP; man_q <= 1'b1; go_q <= 1'b1; kind_q <= CELL_STOP;
               end
            end
            ST_LOST: begin
               if (man_clk9) begin
                  st <= ST_READ; man_q <= 1'b1; bit_idx <= '0;
                  go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= 1'b1;
               end else if (man_stop) begin
                  st <= ST_STOP; man_q <= 1'b1; go_q <= 1'b1; kind_q <= CELL_STOP;
               end
            end
            ST_START, ST_RESTART: begin
               if (cell_done) begin
                  st <= ST_ADDR; bit_idx <= '0;
                  go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= shreg[7];
               end
            end
            ST_ADDR, ST_WRITE: begin
               if (cell_done) begin
                  if (bit_idx <= LSB_SLOT && val_q && !cell_smp) begin
                     st <= ST_IDLE; rel_q <= 1'b1; err_q <= 1'b1;
                     status_q[S_ABORT] <= 1'b1;
                  end else if (bit_idx < LSB_SLOT) begin
                     bit_idx <= bit_idx + 4'd1;
                     shreg   <= {shreg[6:0], 1'b0};
                     go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= shreg[6];
                  end else if (bit_idx == LSB_SLOT) begin
                     bit_idx <= ACK_SLOT;
                     go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= 1'b1;
                  end else if (cell_smp) begin
                     st    <= ST_NOACK;
                     err_q <= 1'b1;
                     if (st == ST_ADDR) status_q[S_NODEV] <= 1'b1;
                     else               status_q[S_DNACK] <= 1'b1;
                  end else begin
                     if (st == ST_WRITE) cnt_dec_q <= 1'b1;
                     if ((st == ST_ADDR && cnt_empty) || (st == ST_WRITE && cnt_last)) begin
                        go_q <= 1'b1;
                        if (stop_q) begin st <= ST_STOP; kind_q <= CELL_STOP; end
                        else begin st <= ST_WAIT; park_q <= 1'b1; kind_q <= CELL_PARK; end
                     end else if (st == ST_ADDR && shreg[7]) begin
                        st <= ST_READ; bit_idx <= '0;
                        go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= 1'b1;
                     end else begin
                        st <= ST_WRITE; bit_idx <= '0; shreg <= tx_data; take_q <= 1'b1;
                        go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= tx_data[7];
                     end
                  end
               end
            end
            ST_READ: begin
               if (cell_done) begin
                  if (man_q) begin
                     if (bit_idx == ACK_SLOT) st <= ST_IDLE;
                     else begin
                        bit_idx <= bit_idx + 4'd1;
                        go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= 1'b1;
                     end
                  end else if (bit_idx < LSB_SLOT) begin
                     shreg   <= {shreg[6:0], cell_smp};
                     bit_idx <= bit_idx + 4'd1;
                     go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= 1'b1;
                  end else if (bit_idx == LSB_SLOT) begin
                     rx_q    <= {shreg[6:0], cell_smp};
                     rxv_q   <= 1'b1;
                     bit_idx <= ACK_SLOT;
                     go_q <= 1'b1; kind_q <= CELL_BIT; val_q <= cnt_last;
                  end else begin
                     cnt_dec_q <= 1'b1;
                     go_q      <= 1'b1;
                     if (cnt_last) begin
                        if (stop_q) begin st <= ST_STOP; kind_q <= CELL_STOP; end
                        else begin st <= ST_WAIT; park_q <= 1'b1; kind_q <= CELL_PARK; end
                     end else begin
                        bit_idx <= '0; kind_q <= CELL_BIT; val_q <= 1'b1;
                     end
                  end
               end
            end
            ST_NOACK: begin
               st <= ST_STOP; go_q <= 1'b1; kind_q <= CELL_STOP;
            end
            ST_STOP: begin
               if (cell_done) begin
                  st <= ST_IDLE;
                  if (!man_q && !err_q) status_q[S_DONE] <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = !(st == ST_IDLE || st == ST_LOST || (st == ST_WAIT && !park_q));
   assign state_code = st;
   assign status     = status_q;
   assign tx_take    = take_q;
   assign rx_data    = rx_q;
   assign rx_valid   = rxv_q;

endmodule

// File: rtl/i2cseq_master_chk.sv
module i2cseq_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_o,
   input logic       sda_o,
   input logic       busy,
   input logic [3:0] state_code,
   input logic [3:0] status,
   input logic       tx_take,
   input logic       rx_valid
);

   // R1 / R13: a settled idle master drives neither line
   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd0 && $past(state_code) == 4'd0) |-> (scl_o && sda_o));

   // R9: parked bus keeps SCL low once the wait state is reached
   p_wait_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd13 && !busy) |-> !scl_o);

   // R11: stuck-bus state leaves the lines alone and is not busy
   p_lost_hands_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd12) |-> (scl_o && sda_o && !busy));

   // R6: done is never reported together with an error
   p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[0] && (status[3:1] != 3'b000)));

   // R3: a transmit byte is consumed only as the write phase runs
   p_take_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> (state_code == 4'd10));

   // R4: received bytes are only delivered in the read phase
   p_rxv_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (state_code == 4'd9));

   // R14: SDA steady while SCL stays high inside address or data bits
   p_sda_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && $past(state_code) == state_code &&
       (state_code == 4'd5 || state_code == 4'd9 || state_code == 4'd10))
      |-> $stable(sda_o));

endmodule

bind i2cseq_master i2cseq_master_chk u_chk (.*);

// File: tb/sim_i2cseq_master.sv
module sim_i2cseq_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic        launch = 1'b0;
   logic [31:0] launch_word = '0;
   logic [6:0]  launch_addr = '0;
   logic        man_clk9 = 1'b0, man_stop = 1'b0, status_rd = 1'b0;
   logic [7:0]  tx_data;
   logic        tx_take, rx_valid, scl_o, sda_o, busy;
   logic [7:0]  rx_data;
   logic [3:0]  state_code, status;

   // bus environment
   logic slv_sda = 1'b1, stuck = 1'b0, rival = 1'b0;
   wire  sda_bus = sda_o & slv_sda & ~stuck & ~rival;

   logic [7:0] txbuf [0:15];
   logic [7:0] rdbuf [0:15];
   int ti = 0, ri = 0;
   assign tx_data = txbuf[ti];

   i2cseq_master u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .launch(launch),
      .launch_word(launch_word), .launch_addr(launch_addr), .man_clk9(man_clk9),
      .man_stop(man_stop), .status_rd(status_rd), .tx_data(tx_data),
      .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid), .sda_i(sda_bus),
      .scl_o(scl_o), .sda_o(sda_o), .busy(busy), .state_code(state_code),
      .status(status)
   );

   always #5 clk = ~clk;

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
   end

   int checks = 0, errors = 0;

   // behavioural slave and bus monitor
   localparam logic [6:0] SLV = 7'h50;
   logic [7:0] rcvd [$];
   logic [7:0] rxq [$];
   logic       macks [$];
   int starts = 0, stops = 0, rises = 0, takes = 0, proto_bad = 0;
   int bitcnt = 0, dbytes = 0, nack_idx = -1, stuck_cnt = 0;
   logic pscl = 1'b1, psda = 1'b1, addr_ph = 1'b0, addressed = 1'b0;
   logic rd_mode = 1'b0, slv_tx = 1'b0, tx_quit = 1'b0;
   logic [7:0] sh = '0, cur = '0;

   initial begin
      forever begin
         @(negedge clk);
         if (tx_take) begin ti++; takes++; end
         if (rx_valid) rxq.push_back(rx_data);
         if (scl_o && pscl && psda && !sda_bus) begin
            starts++; bitcnt = 0; addr_ph = 1'b1; addressed = 1'b0;
            slv_tx = 1'b0; tx_quit = 1'b0; dbytes = 0; slv_sda = 1'b1;
         end else if (scl_o && pscl && !psda && sda_bus) begin
            stops++; addressed = 1'b0; slv_tx = 1'b0; slv_sda = 1'b1;
         end else if (scl_o && !pscl) begin
            rises++;
            if (stuck) begin
               stuck_cnt++;
               if (stuck_cnt == 9) stuck = 1'b0;
            end
            if (bitcnt < 8) begin
               sh = {sh[6:0], sda_bus}; bitcnt++;
            end else if (bitcnt == 8) begin
               if (slv_tx) begin
                  macks.push_back(sda_bus);
                  if (sda_bus) tx_quit = 1'b1;
               end
               bitcnt = 9;
            end
         end else if (!scl_o && pscl) begin
            if (bitcnt == 8) begin
               if (!slv_tx) begin
                  rcvd.push_back(sh);
                  if (addr_ph) begin
                     addr_ph = 1'b0; addressed = (sh[7:1] == SLV); rd_mode = sh[0];
                     slv_sda = !addressed;
                  end else if (addressed) begin
                     slv_sda = (dbytes == nack_idx);
                     dbytes++;
                  end else slv_sda = 1'b1;
               end else slv_sda = 1'b1;
            end else if (bitcnt == 9) begin
               bitcnt = 0;
               if (addressed && rd_mode && !tx_quit) begin
                  slv_tx = 1'b1; cur = rdbuf[ri]; ri++; slv_sda = cur[7];
               end else begin
                  slv_tx = 1'b0; slv_sda = 1'b1;
               end
            end else if (slv_tx && bitcnt < 8) begin
               slv_sda = cur[7 - bitcnt];
            end
         end else if (scl_o && pscl && (sda_bus != psda) && !stuck && !rival) begin
            proto_bad++;
         end
         pscl = scl_o; psda = sda_bus;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_launch(input logic [6:0] a, input logic rw, input logic stp,
                            input int cnt, input logic run);
      @(negedge clk);
      launch_addr = a;
      launch_word = {run, 13'd0, stp, rw, 16'(cnt)};
      launch = 1'b1;
      @(negedge clk);
      launch = 1'b0;
   endtask

   task automatic wait_quiet();
      for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic prep(input int nidx);
      rcvd.delete(); rxq.delete(); macks.delete();
      ti = 0; ri = 0; takes = 0; nack_idx = nidx;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   int s0, p0;

   initial begin
      txbuf[0] = 8'h11; txbuf[1] = 8'h22; txbuf[2] = 8'h33; txbuf[3] = 8'h44;
      for (int i = 4; i < 16; i++) txbuf[i] = 8'(i * 7);
      for (int i = 0; i < 16; i++) rdbuf[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 scl/sda", {scl_o, sda_o}, 2'b11);
      check("R1 busy/state/status", {busy, state_code, status}, 9'd0);

      // R3 R5 write three bytes with stop
      prep(-1); s0 = starts; p0 = stops;
      do_launch(SLV, 1'b0, 1'b1, 3, 1'b1);
      check("R5 busy and start code after launch", {busy, state_code}, {1'b1, 4'd1});
      wait_quiet();
      check("R3 bytes on bus", rcvd.size(), 4);
      if (rcvd.size() == 4)
         check("R3 address and data", {rcvd[0], rcvd[1], rcvd[2], rcvd[3]}, 32'hA0112233);
      check("R3 take pulses", takes, 3);
      check("R3 done status", status, 4'b0001);
      check("R5 idle after stop", {busy, state_code}, 5'd0);
      check("R3 one start one stop", {8'(starts - s0), 8'(stops - p0)}, 16'h0101);

      // R6 status read clears done
      @(negedge clk); status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
      check("R6 status cleared by read", status, 4'b0000);

      // R4 read two bytes
      prep(-1); rdbuf[0] = 8'h3C; rdbuf[1] = 8'hC3;
      do_launch(SLV, 1'b1, 1'b1, 2, 1'b1);
      wait_quiet();
      check("R4 address byte", (rcvd.size() > 0) ? rcvd[0] : 8'hxx, 8'hA1);
      check("R4 received count", rxq.size(), 2);
      if (rxq.size() == 2) check("R4 received data", {rxq[0], rxq[1]}, 16'h3CC3);
      check("R4 ack pattern", macks.size(), 2);
      if (macks.size() == 2) check("R4 ack then nack", {macks[0], macks[1]}, 2'b01);
      check("R4 done", status, 4'b0001);

      // R7 address not acknowledged
      prep(-1); p0 = stops;
      do_launch(7'h33, 1'b0, 1'b1, 2, 1'b1);
      wait_quiet();
      check("R7 no-device flag", status, 4'b1000);
      check("R7 no byte taken", takes, 0);
      check("R7 stop issued", stops - p0, 1);

      // R8 second data byte refused
      prep(1); p0 = stops;
      do_launch(SLV, 1'b0, 1'b1, 3, 1'b1);
      wait_quiet();
      check("R8 data-nack flag", status, 4'b0100);
      check("R8 takes stop at refused byte", takes, 2);
      check("R8 stop issued", stops - p0, 1);

      // R9 parked write then repeated-start read
      prep(-1); s0 = starts; p0 = stops; txbuf[0] = 8'h5A;
      do_launch(SLV, 1'b0, 1'b0, 1, 1'b1);
      wait_quiet();
      check("R9 wait state, not busy", {busy, state_code}, {1'b0, 4'd13});
      check("R9 done while parked", status, 4'b0001);
      check("R9 scl held low", scl_o, 1'b0);
      check("R9 no stop", stops - p0, 0);
      rdbuf[0] = 8'h96;
      do_launch(SLV, 1'b1, 1'b1, 1, 1'b1);
      check("R9 restart code", state_code, 4'd2);
      wait_quiet();
      check("R9 two starts before one stop", {8'(starts - s0), 8'(stops - p0)}, 16'h0201);
      if (rcvd.size() == 3) check("R9 bytes", {rcvd[0], rcvd[1], rcvd[2]}, 24'hA05AA1);
      else check("R9 byte count", rcvd.size(), 3);
      check("R9 read after restart", (rxq.size() == 1) ? rxq[0] : 8'hxx, 8'h96);
      txbuf[0] = 8'h11;

      // R10 zero-length transfer
      prep(-1);
      do_launch(SLV, 1'b0, 1'b1, 0, 1'b1);
      wait_quiet();
      check("R10 address only", rcvd.size(), 1);
      check("R10 done no take", {status, 8'(takes)}, {4'b0001, 8'd0});

      // R2 run bit clear is ignored
      s0 = starts;
      do_launch(SLV, 1'b0, 1'b1, 2, 1'b0);
      repeat (60) @(negedge clk);
      check("R2 ignored launch", {busy, state_code, 8'(starts - s0)}, 13'd0);
      check("R2 status unchanged", status, 4'b0001);

      // R11 stuck SDA, R12 manual recovery
      stuck = 1'b1; stuck_cnt = 0;
      repeat (6) @(negedge clk);
      do_launch(SLV, 1'b0, 1'b1, 1, 1'b1);
      check("R11 lost state", {busy, state_code}, {1'b0, 4'd12});
      check("R11 abort flag", status, 4'b0010);
      do_launch(SLV, 1'b0, 1'b1, 1, 1'b1);
      check("R11 launch ignored when lost", {state_code, scl_o, sda_o}, {4'd12, 2'b11});
      s0 = rises;
      @(negedge clk); man_clk9 = 1'b1; @(negedge clk); man_clk9 = 1'b0;
      check("R12 clock-out code", {busy, state_code}, {1'b1, 4'd9});
      wait_quiet();
      check("R12 nine pulses", rises - s0, 9);
      check("R12 back to idle, bus free", {state_code, 1'(stuck)}, 5'd0);
      p0 = stops;
      @(negedge clk); man_stop = 1'b1; @(negedge clk); man_stop = 1'b0;
      check("R12 stop code", state_code, 4'd3);
      wait_quiet();
      check("R12 stop seen", stops - p0, 1);
      check("R12 no done from manual", {state_code, status[0]}, 5'd0);

      // R13 arbitration loss on address bit
      prep(-1);
      do_launch(SLV, 1'b0, 1'b1, 1, 1'b1);
      for (int i = 0; i < 2000 && state_code != 4'd5; i++) @(negedge clk);
      rival = 1'b1;
      wait_quiet();
      check("R13 abort flag", status, 4'b0010);
      check("R13 idle and released", {state_code, scl_o, sda_o}, {4'd0, 2'b11});
      check("R13 nothing taken", takes, 0);
      rival = 1'b0;
      repeat (4) @(negedge clk);

      // R14 bus protocol over the whole run
      check("R14 sda steady while scl high", proto_bad, 0);
      summary();
   end

endmodule